// File: doc/BRIEF.md
# Deferred-Response SPI Register Slave

This block gives an SPI master access to a small bank of 16-bit registers. Each command frame is 24 bits long. Bit 23 is the direction flag, where 1 means read and 0 means write. Bits 22:16 hold the register address and bits 15:0 hold the data word. The answer to a command does not come back in the same frame. It is shifted out on SDO during the next frame, whatever command that frame carries. A read is therefore followed by any command, and a no-operation command is used when nothing else is pending.

The serial pins are oversampled by the block's system clock. `sclk`, `cs_n` and `sdi` pass through synchronizers, and the block detects edges of the synchronized copies. The SPI clock idles high. SDI is sampled on falling SCLK edges. A frame is taken when chip select rises, and only the last 24 bits received count. The response word is built as follows:
- bit 23 is the direction flag of the command that produced it;
- bit 22 is the CRC-error status;
- bits 21:16 are zero;
- bits 15:0 are the data.

A configuration register at address 1 selects the SCLK edge that launches SDO (bit 0) and can switch the SDO driver off (bit 1).

The control is a three-state machine:
- ST_IDLE waits while chip select is high. When chip select falls it loads the response and moves to ST_XFER.
- ST_XFER shifts bits while chip select is low. When chip select rises it moves to ST_COMMIT if at least 24 falling SCLK edges were seen. Otherwise the frame is dropped and it returns to ST_IDLE.
- ST_COMMIT decodes the frame, performs the access, stores the next response and returns to ST_IDLE.

Top module: `spi_rb_slave`

## Requirements
- R1: SDI is sampled on falling SCLK edges. When chip select rises, the last 24 bits sampled form the command: bit 23 is the direction, 22:16 the address, 15:0 the data. Earlier bits of a longer frame are discarded.
- R2: A write to address 1..NUM_REGS-1 stores the data word. A write to address 0 (no-operation) or to an address at or above NUM_REGS changes nothing, and those addresses read back as 0.
- R3: A read command ignores its data field. The response shifted out during the next frame has bit 23 = 1 and bits 15:0 equal to the addressed register, MSB first.
- R4: The response to a write has bit 23 = 0 and bits 15:0 = 0x0000.
- R5: Response bit 22 equals the `crc_fault` input as it stood when the producing frame ended. Bits 21:16 are 0.
- R6: SCLK cycles beyond 24 in one frame make SDO output the SDI stream delayed by exactly 24 bits.
- R7: The first SDO bit is presented when chip select falls. Later bits are launched on rising SCLK edges when configuration bit 0 is 0, and on falling SCLK edges when it is 1. Bit k is always valid before falling edge k+1.
- R8: `sdo_oe` is 1 only while chip select is low and configuration bit 1 is 0. Otherwise `sdo` is high impedance.
- R9: A frame with fewer than 24 falling SCLK edges performs no register access and leaves the pending response unchanged.
- R10: Reset clears all registers, the configuration and the pending response to 0, and disables SDO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock, idles high |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the master |
| crc_fault | input | 1 | CRC-error status recorded into the next response |
| sdo | output | 1 | Serial data to the master, high impedance when disabled |
| sdo_oe | output | 1 | High while `sdo` is driven |

## Verification
The following are checked on every cycle:
- the SDO enable never rises with chip select high or with the disable bit set;
- a register write only happens when a complete frame was received;
- a short frame returns the machine to ST_IDLE without touching the pending response;
- a write to the configuration register is reflected in the edge-select bit on the next cycle.

Other behaviour spans several frames and only the bench scenarios can show it:
- the one-frame deferral of read data;
- the status and CRC fields;
- the echo of SDI after the 24th bit;
- the half-bit shift of SDO when the falling launch edge is chosen.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int STAT_W  = FRAME_W - 1 - DATA_W;

    // configuration register location and bit positions
    localparam int CFG_ADDR     = 1;
    localparam int CFG_EDGE_BIT = 0;
    localparam int CFG_OFF_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_COMMIT
    } rb_state_e;

    typedef struct packed {
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rb_cmd_t;

    typedef struct packed {
        logic              rw;
        logic              crc;
        logic [STAT_W-2:0] rsvd;
        logic [DATA_W-1:0] data;
    } rb_resp_t;

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int              WIDTH  = 3,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= INIT;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
    import spi_rb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               active,
    input  logic               fall,
    input  logic               launch,
    input  logic               edge_fall,
    input  logic               sdi_bit,
    output logic [FRAME_W-1:0] rx_word,
    output logic               frame_full,
    output logic               sdo_bit
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] rx_q;
    logic [FRAME_W-1:0] tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               echo_bit;

    // on a falling launch edge the bit being sampled is the echo source
    assign echo_bit = edge_fall ? sdi_bit : rx_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (active && fall) begin
            rx_q <= {rx_q[FRAME_W-2:0], sdi_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (active && fall && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (active && launch) begin
            tx_q <= {tx_q[FRAME_W-2:0], echo_bit};
        end
    end

    assign rx_word    = rx_q;
    assign frame_full = (cnt_q == CNT_MAX);
    assign sdo_bit    = tx_q[FRAME_W-1];

endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_edge,
    output logic              cfg_off
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_nop
            assign regs[i] = '0;
        end else begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[i] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                    regs[i] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < LIMIT) begin
            rd_data = regs[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

    assign cfg_edge = regs[CFG_ADDR][CFG_EDGE_BIT];
    assign cfg_off  = regs[CFG_ADDR][CFG_OFF_BIT];

endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    input  logic crc_fault,
    output logic sdo,
    output logic sdo_oe
);

    rb_state_e state, nxt;

    logic       sclk_s, cs_s, sdi_s, sclk_q;
    logic       fall, rise, launch;
    logic       load, active, commit;
    logic       frame_full, sdo_bit;
    logic       cfg_edge, cfg_off;
    logic       wr_en;
    logic [FRAME_W-1:0] rx_word;
    logic [DATA_W-1:0]  rd_data;
    rb_cmd_t    cmd;
    rb_resp_t   resp, resp_nxt;

    spi_rb_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES),
        .INIT  (3'b110)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs_n, sdi}),
        .q    ({sclk_s, cs_s, sdi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_s;
    end

    assign fall   = sclk_q & ~sclk_s;
    assign rise   = ~sclk_q & sclk_s;
    assign launch = cfg_edge ? fall : rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_s) nxt = ST_XFER;
            ST_XFER:   if (cs_s)  nxt = frame_full ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        load   = 1'b0;
        active = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_IDLE:   load   = ~cs_s;
            ST_XFER:   active = ~cs_s;
            ST_COMMIT: commit = 1'b1;
            default:   ;
        endcase
    end

    spi_rb_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (resp),
        .active    (active),
        .fall      (fall),
        .launch    (launch),
        .edge_fall (cfg_edge),
        .sdi_bit   (sdi_s),
        .rx_word   (rx_word),
        .frame_full(frame_full),
        .sdo_bit   (sdo_bit)
    );

    assign cmd   = rb_cmd_t'(rx_word);
    assign wr_en = commit & ~cmd.rw;

    spi_rb_regfile #(
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cmd.addr),
        .wr_data (cmd.data),
        .rd_addr (cmd.addr),
        .rd_data (rd_data),
        .cfg_edge(cfg_edge),
        .cfg_off (cfg_off)
    );

    always_comb begin
        resp_nxt.rw   = cmd.rw;
        resp_nxt.crc  = crc_fault;
        resp_nxt.rsvd = '0;
        resp_nxt.data = cmd.rw ? rd_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      resp <= '0;
        else if (commit) resp <= resp_nxt;
    end

    assign sdo_oe = active & ~cfg_off;
    assign sdo    = sdo_oe ? sdo_bit : 1'bz;

endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk
    import spi_rb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cs_sync,
    input logic               sdo_oe,
    input logic               cfg_off,
    input logic               cfg_edge,
    input rb_state_e          state,
    input logic               frame_full,
    input logic [FRAME_W-1:0] resp,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data
);

    // R8
    off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_off |-> !sdo_oe);

    // R8
    cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |-> !sdo_oe);

    // R9
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && cs_sync && !frame_full) |=> (state == ST_IDLE && $stable(resp)));

    // R2
    full_frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (frame_full && state == ST_COMMIT));

    // R7
    cfg_edge_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CFG_ADDR)) |=> (cfg_edge == $past(wr_data[CFG_EDGE_BIT])));

    // R4
    write_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (resp[FRAME_W-1] == 1'b0 && resp[DATA_W-1:0] == '0));

endmodule

bind spi_rb_slave spi_rb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_sync   (cs_s),
    .sdo_oe    (sdo_oe),
    .cfg_off   (cfg_off),
    .cfg_edge  (cfg_edge),
    .state     (state),
    .frame_full(frame_full),
    .resp      (resp),
    .wr_en     (wr_en),
    .wr_addr   (cmd.addr),
    .wr_data   (cmd.data)
);

// File: tb/tb_spi_rb_slave.sv
module tb_spi_rb_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 6;
    localparam int NVEC       = 10;

    // each entry: {command[23:0], expected response seen in that frame[23:0]}
    localparam logic [47:0] VECS [NVEC] = '{
        {24'h02A5C3, 24'h000000},  // write r2
        {24'h031234, 24'h000000},  // write r3
        {24'h82FFFF, 24'h000000},  // read r2, data field ignored
        {24'h830000, 24'h80A5C3},  // read r3, r2 returned
        {24'h00BEEF, 24'h801234},  // write nop register
        {24'h800000, 24'h000000},  // read r0
        {24'h097777, 24'h800000},  // write out-of-range address 9
        {24'h890000, 24'h000000},  // read address 9
        {24'h870000, 24'h800000},  // read r7, address 9 returned 0
        {24'h000000, 24'h800000}   // nop, r7 returned 0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic crc_fault = 1'b0;
    logic sdo;
    logic sdo_oe;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] dout, dmid;
    logic oe_any, oe_all;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rb_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .crc_fault(crc_fault),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // master: n bits, din[n-1] first; dout = SDO before each fall, dmid = SDO before each rise
    task automatic xfer(input int n, input logic [63:0] din);
        dout = '0; dmid = '0; oe_any = 1'b0; oe_all = 1'b1;
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdi = din[n-1-i];
            wait_clk(HALF_BIT);
            dout[n-1-i] = sdo;
            oe_any |= sdo_oe;
            oe_all &= sdo_oe;
            sclk = 1'b0;
            wait_clk(HALF_BIT);
            dmid[n-1-i] = sdo;
            sclk = 1'b1;
        end
        wait_clk(HALF_BIT);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic frame24(input logic [23:0] cmd, input logic [23:0] exp, input string req);
        xfer(24, {40'h0, cmd});
        check(dout[23:0] == exp, req, {40'h0, dout[23:0]}, {40'h0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        // R10 reset state
        check(sdo_oe == 1'b0, "R10 sdo_oe in reset", {63'h0, sdo_oe}, 64'h0);
        rst_n = 1'b1;
        wait_clk(5);
        check(sdo_oe == 1'b0, "R8 sdo_oe with cs high", {63'h0, sdo_oe}, 64'h0);

        // table: R1 R2 R3 R4 deferred responses
        for (int v = 0; v < NVEC; v++) begin
            frame24(VECS[v][47:24], VECS[v][23:0], "R2/R3/R4 table frame");
            check(oe_all == 1'b1, "R8 sdo driven while cs low", {63'h0, oe_all}, 64'h1);
        end

        // R7 rising launch: SDO unchanged across the falling edge
        frame24(24'h830000, 24'h000000, "R3 read r3");
        frame24(24'h000000, 24'h801234, "R3 read r3 data");
        check(dmid[23:0] == dout[23:0], "R7 rising launch hold", dmid, dout);

        // R5 CRC status
        crc_fault = 1'b1;
        frame24(24'h820000, 24'h000000, "R5 frame with crc fault");
        crc_fault = 1'b0;
        frame24(24'h000000, 24'hC0A5C3, "R5 crc flag set");
        frame24(24'h830000, 24'h000000, "R5 crc flag clear");

        // R9 short frame: no access, pending response kept
        xfer(10, 64'h3FF);
        check(sdo_oe == 1'b0, "R8 sdo_oe after frame", {63'h0, sdo_oe}, 64'h0);
        frame24(24'h000000, 24'h801234, "R9 pending response kept");
        frame24(24'h830000, 24'h000000, "R9 nop response");
        frame24(24'h000000, 24'h801234, "R9 r3 unchanged");

        // R1 R6 long frame: last 24 bits used, extra clocks echo SDI
        xfer(32, {32'h0, 8'hC6, 24'h045A5A});
        check(dout[31:8] == 24'h000000, "R6 response part of long frame", {40'h0, dout[31:8]}, 64'h0);
        check(dout[7:0] == 8'hC6, "R6 echo of SDI", {56'h0, dout[7:0]}, 64'hC6);
        frame24(24'h840000, 24'h000000, "R1 long-frame write response");
        frame24(24'h000000, 24'h805A5A, "R1 right-justified write");

        // R7 falling launch edge
        frame24(24'h010001, 24'h000000, "R7 cfg write");
        frame24(24'h830000, 24'h000000, "R7 read r3");
        frame24(24'h000000, 24'h801234, "R7 falling launch data");
        check(dmid[23:1] == dout[22:0], "R7 falling launch early bit", {41'h0, dmid[23:1]}, {41'h0, dout[22:0]});
        xfer(32, {32'h0, 8'h3A, 24'h000000});
        check(dout[7:0] == 8'h3A, "R6 echo with falling launch", {56'h0, dout[7:0]}, 64'h3A);

        // R8 SDO disable
        frame24(24'h010002, 24'h000000, "R8 cfg off write");
        check(oe_all == 1'b1, "R8 enabled during cfg write", {63'h0, oe_all}, 64'h1);
        xfer(24, 64'h000000);
        check(oe_any == 1'b0, "R8 sdo disabled", {63'h0, oe_any}, 64'h0);
        xfer(24, 64'h010000);
        check(oe_any == 1'b0, "R8 sdo still disabled", {63'h0, oe_any}, 64'h0);
        frame24(24'h000000, 24'h000000, "R8 re-enabled response");
        check(oe_all == 1'b1, "R8 sdo re-enabled", {63'h0, oe_all}, 64'h1);

        // R10 reset mid-run
        frame24(24'h051111, 24'h000000, "R2 write r5");
        rst_n = 1'b0;
        wait_clk(3);
        check(sdo_oe == 1'b0, "R10 sdo_oe during reset", {63'h0, sdo_oe}, 64'h0);
        rst_n = 1'b1;
        wait_clk(3);
        frame24(24'h850000, 24'h000000, "R10 pending response cleared");
        frame24(24'h000000, 24'h800000, "R10 r5 cleared");

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule